// File: doc/BRIEF.md
# Supervised Operating Mode Controller

This block is the operating-mode state machine of a supervisory companion chip. It accepts 3-bit mode-register writes, tracks whether the system is in Normal, Start-up, Flash or Fail-safe mode, and requests system resets. Each reset request carries a 4-bit code that names its cause.

Flash mode is guarded. While in Normal mode, three consecutive writes that each fall inside the legal watchdog window must carry the codes 111, 001 and 111. When that sequence completes, the controller enters Start-up and requests a reset. Once the processor comes back from that reset, it writes a one-time handshake code to enter Flash mode. In Flash mode only the service code keeps the part running. The leave code exits with its own reset cause. Any other code, or a watchdog overflow, forces a reset.

A failing oscillator moves the controller to Fail-safe mode at once. It stays there until the oscillator is good again and a wake-up event arrives.

Top module: `mode_supervisor`

States: `MD_NORMAL` (00), `MD_STARTUP` (01), `MD_FLASH` (10), `MD_FAILSAFE` (11).

Transitions:
- `arm_done`: Normal to Start-up.
- `wdt_trip`: Normal or Flash to Start-up.
- `handshake`: Start-up to Flash.
- `back_to_normal`: Start-up to Normal.
- `startup_tmo`: Start-up to Start-up.
- `flash_leave`: Flash to Start-up.
- `flash_illegal`: Flash to Start-up.
- `osc_loss`: any state to Fail-safe.
- `revive`: Fail-safe to Start-up.

## Requirements
- R1: After reset, `mode` is 00 (Normal), `rst_req` is 0 and `rst_src` is 0000. The mode encoding is 00 Normal, 01 Start-up, 10 Flash, 11 Fail-safe.
- R2: In Normal, three consecutive in-window writes of 111, 001 and 111 move the mode to Start-up one cycle after the third write. In the same cycle the block pulses `rst_req` with `rst_src` = 0110, and Flash entry becomes armed.
- R3: In Normal, an in-window write that does not match the expected next code clears the arming progress to zero, and so does any write with `win_ok` low. A following in-window 111 counts as step one again.
- R4: In Start-up, a write of 011 while Flash entry is armed enters Flash with no reset and consumes the arming. A write of 011 while not armed is ignored.
- R5: In Start-up, a write of 101 returns to Normal with no reset and clears the armed state.
- R6: In Flash, a write of 111 serves the watchdog: the mode stays Flash and no reset is requested.
- R7: In Flash, a write of 110 moves the mode to Start-up and requests a reset with `rst_src` = 0111.
- R8: In Flash, a write of any code other than 111 or 110 moves the mode to Start-up and requests a reset with `rst_src` = 1000.
- R9: A watchdog overflow in Normal or Flash moves the mode to Start-up and requests a reset with `rst_src` = 0010. It takes priority over a write in the same cycle.
- R10: If the mode stays in Start-up with no leaving write, `rst_req` pulses with `rst_src` = 0100 exactly STARTUP_CYCLES clock edges after entry. The mode stays Start-up and the timeout restarts.
- R11: `osc_fail` high moves the mode to Fail-safe on the next edge from any mode, with no reset request. It overrides every other input.
- R12: Fail-safe is left only when `wake` is high while `osc_fail` is low. The mode then moves to Start-up and a reset is requested with `rst_src` = 0011.
- R13: `rst_req` is high for single cycles only. `rst_src` keeps its last value between requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Mode-register write strobe |
| wr_code | input | 3 | Mode code carried by the write |
| win_ok | input | 1 | Write falls inside the legal watchdog window |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| osc_fail | input | 1 | Oscillator slow or stopped |
| wake | input | 1 | Wake-up event |
| mode | output | 2 | Current operating mode |
| rst_req | output | 1 | Single-cycle system reset request |
| rst_src | output | 4 | Cause of the latest reset request |

## Verification
Some properties are checked by assertions on every cycle:
- the single-cycle reset pulse and that every request carries a nonzero cause;
- the immediate move to Fail-safe, and staying there until a wake arrives with a good oscillator;
- that Flash is never entered without a 011 write in Start-up;
- the overflow path out of Flash.

Other properties only the bench scenarios can show. These are the ordering and window rules of the arming sequence, the one-shot nature of the handshake, the exact cycle on which the start-up timeout fires, and the cause codes for each exit path.

// File: rtl/mode_sup_pkg.sv
package mode_sup_pkg;

    typedef enum logic [1:0] {
        MD_NORMAL   = 2'b00,
        MD_STARTUP  = 2'b01,
        MD_FLASH    = 2'b10,
        MD_FAILSAFE = 2'b11
    } mode_e;

    localparam int CODE_W = 3;
    localparam int SRC_W  = 4;

    // write codes
    localparam logic [CODE_W-1:0] C_SEQ_A   = 3'b111;
    localparam logic [CODE_W-1:0] C_SEQ_B   = 3'b001;
    localparam logic [CODE_W-1:0] C_SERVE   = 3'b111;
    localparam logic [CODE_W-1:0] C_HSHAKE  = 3'b011;
    localparam logic [CODE_W-1:0] C_RETURN  = 3'b101;
    localparam logic [CODE_W-1:0] C_LEAVE   = 3'b110;

    // reset causes
    localparam logic [SRC_W-1:0] S_NONE     = 4'b0000;
    localparam logic [SRC_W-1:0] S_WDT      = 4'b0010;
    localparam logic [SRC_W-1:0] S_WAKE     = 4'b0011;
    localparam logic [SRC_W-1:0] S_TMO      = 4'b0100;
    localparam logic [SRC_W-1:0] S_FL_IN    = 4'b0110;
    localparam logic [SRC_W-1:0] S_FL_OUT   = 4'b0111;
    localparam logic [SRC_W-1:0] S_ILLEGAL  = 4'b1000;

endpackage

// File: rtl/msup_arm_seq.sv
module msup_arm_seq
    import mode_sup_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_valid,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              win_ok,
    output logic              done
);
    localparam int STEPS = 3;
    localparam int PW    = $clog2(STEPS);

    logic [PW-1:0]     prog_q;
    logic [CODE_W-1:0] want;

    always_comb begin
        unique case (prog_q)
            PW'(1):  want = C_SEQ_B;
            default: want = C_SEQ_A;
        endcase
    end

    logic hit;
    assign hit  = enable && wr_valid && win_ok && (wr_code == want);
    assign done = hit && (prog_q == PW'(STEPS-1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_q <= '0;
        end else if (!enable || done) begin
            prog_q <= '0;
        end else if (wr_valid) begin
            prog_q <= hit ? prog_q + PW'(1) : '0;
        end
    end
endmodule

// File: rtl/msup_startup_timer.sv
module msup_startup_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expire = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/msup_fsm.sv
module msup_fsm
    import mode_sup_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wdt_ovf,
    input  logic              osc_fail,
    input  logic              wake,
    input  logic              arm_done,
    input  logic              tmo,
    output mode_e             state,
    output logic              req,
    output logic [SRC_W-1:0]  src
);
    mode_e            state_d;
    logic             armed_q, armed_d;
    logic             req_d;
    logic [SRC_W-1:0] src_d;

    always_comb begin
        state_d = state;
        armed_d = armed_q;
        req_d   = 1'b0;
        src_d   = src;
        if (osc_fail) begin
            state_d = MD_FAILSAFE;       // osc_loss
            armed_d = 1'b0;
        end else begin
            unique case (state)
                MD_NORMAL: begin
                    if (wdt_ovf) begin   // wdt_trip
                        state_d = MD_STARTUP;
                        req_d   = 1'b1;
                        src_d   = S_WDT;
                    end else if (arm_done) begin
                        state_d = MD_STARTUP;
                        req_d   = 1'b1;
                        src_d   = S_FL_IN;
                        armed_d = 1'b1;
                    end
                end
                MD_STARTUP: begin
                    if (wr_valid && wr_code == C_HSHAKE && armed_q) begin
                        state_d = MD_FLASH;
                        armed_d = 1'b0;
                    end else if (wr_valid && wr_code == C_RETURN) begin
                        state_d = MD_NORMAL;
                        armed_d = 1'b0;
                    end else if (tmo) begin
                        req_d   = 1'b1;
                        src_d   = S_TMO;
                    end
                end
                MD_FLASH: begin
                    if (wdt_ovf) begin
                        state_d = MD_STARTUP;
                        req_d   = 1'b1;
                        src_d   = S_WDT;
                    end else if (wr_valid && wr_code != C_SERVE) begin
                        state_d = MD_STARTUP;
                        req_d   = 1'b1;
                        src_d   = (wr_code == C_LEAVE) ? S_FL_OUT : S_ILLEGAL;
                    end
                end
                MD_FAILSAFE: begin
                    if (wake) begin      // revive
                        state_d = MD_STARTUP;
                        req_d   = 1'b1;
                        src_d   = S_WAKE;
                    end
                end
                default: state_d = MD_NORMAL;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= MD_NORMAL;
            armed_q <= 1'b0;
        end else begin
            state   <= state_d;
            armed_q <= armed_d;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req <= 1'b0;
            src <= S_NONE;
        end else begin
            req <= req_d;
            src <= src_d;
        end
    end
endmodule

// File: rtl/mode_supervisor.sv
module mode_supervisor
    import mode_sup_pkg::*;
#(
    parameter int STARTUP_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  logic [2:0] wr_code,
    input  logic       win_ok,
    input  logic       wdt_ovf,
    input  logic       osc_fail,
    input  logic       wake,
    output logic [1:0] mode,
    output logic       rst_req,
    output logic [3:0] rst_src
);
    mode_e state;
    logic  arm_done;
    logic  tmo;

    msup_arm_seq u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (state == MD_NORMAL),
        .wr_valid (wr_valid),
        .wr_code  (wr_code),
        .win_ok   (win_ok),
        .done     (arm_done)
    );

    msup_startup_timer #(.LIMIT(STARTUP_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == MD_STARTUP),
        .expire (tmo)
    );

    msup_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_code  (wr_code),
        .wdt_ovf  (wdt_ovf),
        .osc_fail (osc_fail),
        .wake     (wake),
        .arm_done (arm_done),
        .tmo      (tmo),
        .state    (state),
        .req      (rst_req),
        .src      (rst_src)
    );

    assign mode = state;
endmodule

// File: rtl/mode_supervisor_chk.sv
module mode_supervisor_chk
    import mode_sup_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_valid,
    input logic [2:0] wr_code,
    input logic       win_ok,
    input logic       wdt_ovf,
    input logic       osc_fail,
    input logic       wake,
    input logic [1:0] mode,
    input logic       rst_req,
    input logic [3:0] rst_src
);
    a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    a_r13_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> rst_src != S_NONE);

    a_r11_osc_loss: assert property (@(posedge clk) disable iff (!rst_n)
        osc_fail |=> (mode == MD_FAILSAFE) && !rst_req);

    a_r12_hold_failsafe: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_FAILSAFE && (osc_fail || !wake)) |=> mode == MD_FAILSAFE);

    a_r4_flash_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MD_FLASH &&
         !(mode == MD_STARTUP && wr_valid && wr_code == C_HSHAKE))
        |=> mode != MD_FLASH);

    a_r9_flash_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_FLASH && wdt_ovf && !osc_fail)
        |=> mode == MD_STARTUP && rst_req && rst_src == S_WDT);

    a_r6_flash_serve: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_FLASH && wr_valid && wr_code == C_SERVE && !wdt_ovf && !osc_fail)
        |=> mode == MD_FLASH && !rst_req);
endmodule

bind mode_supervisor mode_supervisor_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_code  (wr_code),
    .win_ok   (win_ok),
    .wdt_ovf  (wdt_ovf),
    .osc_fail (osc_fail),
    .wake     (wake),
    .mode     (mode),
    .rst_req  (rst_req),
    .rst_src  (rst_src)
);

// File: tb/mode_supervisor_test.sv
module mode_supervisor_test;
    localparam int LIM = 16;
    localparam int NV  = 41;

    // act: 0 idle, 1 write, 2 ovf, 3 osc, 4 wake, 5 wake+osc, 6 ovf+write
    // vector = {act[3], code[3], win, mode[2], req, src[4]}
    localparam logic [13:0] VEC [NV] = '{
        {3'd1, 3'b111, 1'b1, 2'd0, 1'b0, 4'h0},  // 0  R2 step
        {3'd1, 3'b001, 1'b1, 2'd0, 1'b0, 4'h0},  // 1  R2 step
        {3'd1, 3'b111, 1'b1, 2'd1, 1'b1, 4'h6},  // 2  R2 done
        {3'd1, 3'b011, 1'b0, 2'd2, 1'b0, 4'h6},  // 3  R4 handshake
        {3'd1, 3'b111, 1'b0, 2'd2, 1'b0, 4'h6},  // 4  R6 serve
        {3'd1, 3'b110, 1'b0, 2'd1, 1'b1, 4'h7},  // 5  R7 leave
        {3'd1, 3'b011, 1'b0, 2'd1, 1'b0, 4'h7},  // 6  R4 not armed
        {3'd1, 3'b101, 1'b0, 2'd0, 1'b0, 4'h7},  // 7  R5
        {3'd1, 3'b111, 1'b1, 2'd0, 1'b0, 4'h7},  // 8
        {3'd1, 3'b001, 1'b0, 2'd0, 1'b0, 4'h7},  // 9  R3 out of window
        {3'd1, 3'b111, 1'b1, 2'd0, 1'b0, 4'h7},  // 10
        {3'd1, 3'b001, 1'b1, 2'd0, 1'b0, 4'h7},  // 11
        {3'd1, 3'b111, 1'b1, 2'd1, 1'b1, 4'h6},  // 12 R2
        {3'd1, 3'b101, 1'b0, 2'd0, 1'b0, 4'h6},  // 13 R5 clears armed
        {3'd1, 3'b011, 1'b0, 2'd0, 1'b0, 4'h6},  // 14 ignored in Normal
        {3'd1, 3'b111, 1'b1, 2'd0, 1'b0, 4'h6},  // 15
        {3'd1, 3'b111, 1'b1, 2'd0, 1'b0, 4'h6},  // 16 R3 order broken
        {3'd1, 3'b001, 1'b1, 2'd0, 1'b0, 4'h6},  // 17
        {3'd1, 3'b111, 1'b1, 2'd0, 1'b0, 4'h6},  // 18 R3 restart
        {3'd1, 3'b001, 1'b1, 2'd0, 1'b0, 4'h6},  // 19
        {3'd1, 3'b111, 1'b1, 2'd1, 1'b1, 4'h6},  // 20
        {3'd1, 3'b011, 1'b0, 2'd2, 1'b0, 4'h6},  // 21
        {3'd1, 3'b010, 1'b0, 2'd1, 1'b1, 4'h8},  // 22 R8 illegal
        {3'd1, 3'b011, 1'b0, 2'd1, 1'b0, 4'h8},  // 23 R4 one-shot
        {3'd1, 3'b101, 1'b0, 2'd0, 1'b0, 4'h8},  // 24
        {3'd1, 3'b111, 1'b1, 2'd0, 1'b0, 4'h8},  // 25
        {3'd1, 3'b001, 1'b1, 2'd0, 1'b0, 4'h8},  // 26
        {3'd1, 3'b111, 1'b1, 2'd1, 1'b1, 4'h6},  // 27
        {3'd1, 3'b011, 1'b0, 2'd2, 1'b0, 4'h6},  // 28
        {3'd6, 3'b110, 1'b0, 2'd1, 1'b1, 4'h2},  // 29 R9 priority
        {3'd1, 3'b101, 1'b0, 2'd0, 1'b0, 4'h2},  // 30
        {3'd3, 3'b000, 1'b0, 2'd3, 1'b0, 4'h2},  // 31 R11
        {3'd5, 3'b000, 1'b0, 2'd3, 1'b0, 4'h2},  // 32 R12 osc still bad
        {3'd4, 3'b000, 1'b0, 2'd1, 1'b1, 4'h3},  // 33 R12 revive
        {3'd1, 3'b101, 1'b0, 2'd0, 1'b0, 4'h3},  // 34
        {3'd0, 3'b000, 1'b0, 2'd0, 1'b0, 4'h3},  // 35 R13 hold
        {3'd1, 3'b111, 1'b1, 2'd0, 1'b0, 4'h3},  // 36
        {3'd1, 3'b001, 1'b1, 2'd0, 1'b0, 4'h3},  // 37
        {3'd3, 3'b000, 1'b0, 2'd3, 1'b0, 4'h3},  // 38 R11 from Normal
        {3'd4, 3'b000, 1'b0, 2'd1, 1'b1, 4'h3},  // 39
        {3'd1, 3'b101, 1'b0, 2'd0, 1'b0, 4'h3}   // 40
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [2:0] wr_code = '0;
    logic       win_ok = 1'b0;
    logic       wdt_ovf = 1'b0;
    logic       osc_fail = 1'b0;
    logic       wake = 1'b0;
    logic [1:0] mode;
    logic       rst_req;
    logic [3:0] rst_src;

    int checks = 0;
    int errs   = 0;

    always #2.5 clk = ~clk;

    mode_supervisor #(.STARTUP_CYCLES(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_code(wr_code),
        .win_ok(win_ok), .wdt_ovf(wdt_ovf), .osc_fail(osc_fail), .wake(wake),
        .mode(mode), .rst_req(rst_req), .rst_src(rst_src)
    );

    task automatic check(input string tag, input logic [1:0] em,
                         input logic er, input logic [3:0] es);
        checks++;
        if (mode !== em || rst_req !== er || rst_src !== es) begin
            errs++;
            $display("FAIL %s: mode=%0d req=%0b src=%b, expected mode=%0d req=%0b src=%b",
                     tag, mode, rst_req, rst_src, em, er, es);
        end
    endtask

    task automatic clear_in();
        wr_valid = 1'b0; wr_code = '0; win_ok = 1'b0;
        wdt_ovf = 1'b0; osc_fail = 1'b0; wake = 1'b0;
    endtask

    task automatic apply(input logic [2:0] act, input logic [2:0] code, input logic win);
        @(negedge clk);
        wr_code = code;
        win_ok  = win;
        wr_valid = (act == 3'd1 || act == 3'd6);
        wdt_ovf  = (act == 3'd2 || act == 3'd6);
        osc_fail = (act == 3'd3 || act == 3'd5);
        wake     = (act == 3'd4 || act == 3'd5);
        @(negedge clk);
        clear_in();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        clear_in();
        repeat (3) @(negedge clk);
        check("R1 reset state", 2'd0, 1'b0, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 2'd0, 1'b0, 4'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][13:11], VEC[i][10:8], VEC[i][7]);
            check($sformatf("vector %0d (R2..R13)", i),
                  VEC[i][6:5], VEC[i][4], VEC[i][3:0]);
        end

        // R9: overflow from Normal, then R10 start-up timeout timing
        apply(3'd2, 3'b000, 1'b0);
        check("R9 overflow in Normal", 2'd1, 1'b1, 4'h2);
        for (int k = 1; k < LIM; k++) begin
            @(negedge clk);
            check("R10 before timeout", 2'd1, 1'b0, 4'h2);
        end
        @(negedge clk);
        check("R10 first timeout", 2'd1, 1'b1, 4'h4);
        for (int k = 1; k < LIM; k++) begin
            @(negedge clk);
            check("R10 timer restart", 2'd1, 1'b0, 4'h4);
        end
        @(negedge clk);
        check("R10 second timeout", 2'd1, 1'b1, 4'h4);
        @(negedge clk);
        check("R13 pulse ends", 2'd1, 1'b0, 4'h4);

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", 2'd0, 1'b0, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stays Normal", 2'd0, 1'b0, 4'h0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule